// File: doc/BRIEF.md
# Pulse-Width State Request Codec

Several devices share one open-drain line that idles high while they are in their active or standby states. Any device may ask for a state change by pulling the line low, and the length of that low pulse is the only thing that says which change is wanted: a short pulse toggles between standby and active, and a long pulse asks for OFF. Every device, including the one that sent the pulse, times the low period and decodes it when the line rises again, so all devices act on the same request at the same moment.

The codec has a transmit side and a receive side. The transmit side drives a pull-down enable for a fixed number of cycles that depends on the request kind. The receive side synchronizes the line, counts the low cycles, and emits a one-cycle decode strobe with the decoded kind. The decode windows are much wider than the nominal pulses, so devices whose clocks differ by tens of percent still agree. A low period that reaches the timeout is reported as a line fault. Pulses that overlap, from this device or from others, merge on the wire into one longer low period, and the codec decodes that merged pulse once. All durations are parameters counted in clock cycles.

Top module: `pwreq_codec`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `line_pull`, `evt_valid` and `fault` are 0.
- R2: A request with `req_kind`=0 (standby/active toggle) accepted at a clock edge sets `line_pull` to 1 from that edge for exactly TX_SHORT_CYC cycles.
- R3: A request with `req_kind`=1 (OFF) accepted at a clock edge sets `line_pull` to 1 from that edge for exactly TX_LONG_CYC cycles.
- R4: The low time is counted in cycles of the line after a two-flop synchronizer; `evt_valid` is a single-cycle strobe that goes high in the third cycle after `line_in` returns high.
- R5: A low time from RX_SHORT_MIN to RX_SHORT_MAX cycles, both inclusive, produces `evt_valid` with `evt_kind`=0.
- R6: A low time from RX_LONG_MIN to RX_LONG_MAX cycles, both inclusive, produces `evt_valid` with `evt_kind`=1.
- R7: Any other low time shorter than RX_TIMEOUT cycles produces no strobe.
- R8: When the low time reaches RX_TIMEOUT cycles, `fault` goes high and stays high until the synchronized line is high again; the rising edge that ends such a pulse produces no strobe.
- R9: A request is ignored, with `line_pull` left at 0, while the codec is still driving its own pulse, while the synchronized line is low, or while a low period is still being decoded.
- R10: A request launched in the same cycle as another device's pulse merges with it; one strobe is produced, decoded from the total low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to send a state change, sampled each cycle |
| req_kind | input | 1 | Kind of request: 0 standby/active toggle, 1 OFF |
| line_in | input | 1 | Level of the shared line (asynchronous) |
| line_pull | output | 1 | Pull-down enable for the shared line, 1 drives it low |
| evt_valid | output | 1 | One-cycle strobe: a request was decoded |
| evt_kind | output | 1 | Decoded kind: 0 toggle, 1 OFF; valid with `evt_valid` |
| fault | output | 1 | Line held low for the timeout or longer |

## Verification
The bench builds the codec with short cycle counts: a 9-cycle toggle pulse, a 42-cycle OFF pulse, windows of 6 to 20 and 30 to 60 cycles and an 80-cycle timeout. With these values every window edge, the gaps between the windows and the fault timeout are reached within a few hundred cycles, so each decode boundary is tested at both its inside and outside value. A second device is modeled by a bench pull-down, which makes merged pulses, requests that arrive while the line is busy, and stuck-low faults reachable against a per-cycle reference model.

// File: rtl/pwreq_pkg.sv
package pwreq_pkg;

  // Kind of state request, carried only by the pulse length on the wire
  typedef enum logic {
    KIND_TOGGLE = 1'b0,
    KIND_OFF    = 1'b1
  } req_kind_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/pwreq_sync.sv
module pwreq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[i] <= 1'b1;
        end else if (i == 0) begin
          chain[i] <= d_async;
        end else begin
          chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pwreq_tx.sv
module pwreq_tx
  import pwreq_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 4500,
  parameter int unsigned LONG_CYC  = 21000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  req_kind_e kind,
  output logic      pull,
  output logic      active
);

  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CW   = cnt_width(MAXC);
  localparam logic [CW-1:0] SHORT_LEN = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_LEN  = CW'(LONG_CYC);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      pull <= 1'b0;
    end else if (left != '0) begin
      left <= left - ONE;
      pull <= (left != ONE);
    end else if (start) begin
      left <= (kind == KIND_OFF) ? LONG_LEN : SHORT_LEN;
      pull <= 1'b1;
    end
  end

  assign active = (left != '0);

endmodule

// File: rtl/pwreq_rx.sv
module pwreq_rx
  import pwreq_pkg::*;
#(
  parameter int unsigned SHORT_MIN = 3000,
  parameter int unsigned SHORT_MAX = 10000,
  parameter int unsigned LONG_MIN  = 15000,
  parameter int unsigned LONG_MAX  = 30000,
  parameter int unsigned TIMEOUT   = 40000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      line_s,
  output logic      evt_valid,
  output req_kind_e evt_kind,
  output logic      fault,
  output logic      busy
);

  localparam int unsigned CW = cnt_width(TIMEOUT);
  localparam logic [CW-1:0] S_MIN  = CW'(SHORT_MIN);
  localparam logic [CW-1:0] S_MAX  = CW'(SHORT_MAX);
  localparam logic [CW-1:0] L_MIN  = CW'(LONG_MIN);
  localparam logic [CW-1:0] L_MAX  = CW'(LONG_MAX);
  localparam logic [CW-1:0] TO_CNT = CW'(TIMEOUT);
  localparam logic [CW-1:0] TO_M1  = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] low_cnt;
  logic          in_short;
  logic          in_long;

  assign in_short = (low_cnt >= S_MIN) && (low_cnt <= S_MAX);
  assign in_long  = (low_cnt >= L_MIN) && (low_cnt <= L_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      evt_valid <= 1'b0;
      evt_kind  <= KIND_TOGGLE;
      fault     <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      if (!line_s) begin
        if (low_cnt != TO_CNT) low_cnt <= low_cnt + ONE;
        fault <= (low_cnt >= TO_M1);
      end else begin
        if (in_short) begin
          evt_valid <= 1'b1;
          evt_kind  <= KIND_TOGGLE;
        end else if (in_long) begin
          evt_valid <= 1'b1;
          evt_kind  <= KIND_OFF;
        end
        low_cnt <= '0;
        fault   <= 1'b0;
      end
    end
  end

  assign busy = !line_s || (low_cnt != '0);

endmodule

// File: rtl/pwreq_codec.sv
module pwreq_codec
  import pwreq_pkg::*;
#(
  parameter int unsigned TX_SHORT_CYC = 4500,
  parameter int unsigned TX_LONG_CYC  = 21000,
  parameter int unsigned RX_SHORT_MIN = 3000,
  parameter int unsigned RX_SHORT_MAX = 10000,
  parameter int unsigned RX_LONG_MIN  = 15000,
  parameter int unsigned RX_LONG_MAX  = 30000,
  parameter int unsigned RX_TIMEOUT   = 40000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_kind,
  input  logic line_in,
  output logic line_pull,
  output logic evt_valid,
  output logic evt_kind,
  output logic fault
);

  logic      line_s;
  logic      rx_busy;
  logic      tx_active;
  logic      launch;
  req_kind_e kind_in;
  req_kind_e kind_out;

  assign kind_in = req_kind_e'(req_kind);
  assign launch  = req_valid && !rx_busy && !tx_active;

  pwreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (line_in),
    .q_sync  (line_s)
  );

  pwreq_tx #(
    .SHORT_CYC (TX_SHORT_CYC),
    .LONG_CYC  (TX_LONG_CYC)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .start  (launch),
    .kind   (kind_in),
    .pull   (line_pull),
    .active (tx_active)
  );

  pwreq_rx #(
    .SHORT_MIN (RX_SHORT_MIN),
    .SHORT_MAX (RX_SHORT_MAX),
    .LONG_MIN  (RX_LONG_MIN),
    .LONG_MAX  (RX_LONG_MAX),
    .TIMEOUT   (RX_TIMEOUT)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .line_s    (line_s),
    .evt_valid (evt_valid),
    .evt_kind  (kind_out),
    .fault     (fault),
    .busy      (rx_busy)
  );

  assign evt_kind = kind_out;

endmodule

// File: rtl/pwreq_codec_chk.sv
module pwreq_codec_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic line_in,
  input logic line_pull,
  input logic evt_valid,
  input logic fault
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!line_pull && !evt_valid && !fault));

  // R2
  pull_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pull) |-> $past(req_valid));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);

  // R4
  strobe_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> ($past(line_in, 3) && !$past(line_in, 4)));

  // R8
  fault_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> !evt_valid);

  // R8
  fault_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> !$past(line_in, 2));

endmodule

bind pwreq_codec pwreq_codec_chk u_chk (.*);

// File: tb/sim_pwreq_codec.sv
`timescale 1ns/100ps
module sim_pwreq_codec;

  localparam int TXS = 9;
  localparam int TXL = 42;
  localparam int SMIN = 6;
  localparam int SMAX = 20;
  localparam int LMIN = 30;
  localparam int LMAX = 60;
  localparam int TOUT = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_kind = 1'b0;
  logic ext_pull = 1'b0;
  logic line_in;
  logic line_pull, evt_valid, evt_kind, fault;

  always #2.5 clk = ~clk;

  assign line_in = !(line_pull || ext_pull);

  pwreq_codec #(
    .TX_SHORT_CYC(TXS), .TX_LONG_CYC(TXL),
    .RX_SHORT_MIN(SMIN), .RX_SHORT_MAX(SMAX),
    .RX_LONG_MIN(LMIN), .RX_LONG_MAX(LMAX),
    .RX_TIMEOUT(TOUT), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .line_in(line_in), .line_pull(line_pull), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .fault(fault)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_pull, m_evt, m_kind, m_fault;
  int m_left, m_low;
  bit hist[$];

  always @(posedge clk) begin
    bit now_lvl, seen, busy;
    if (rst) begin
      m_pull = 0; m_evt = 0; m_kind = 0; m_fault = 0;
      m_left = 0; m_low = 0;
      hist = {1'b1, 1'b1};
    end else begin
      now_lvl = !(m_pull || ext_pull);
      seen = hist.pop_front();
      hist.push_back(now_lvl);
      busy = (m_left > 0) || !seen || (m_low > 0);
      m_evt = 0;
      if (!seen) begin
        if (m_low < TOUT) m_low++;
        m_fault = (m_low == TOUT);
      end else begin
        if (m_low >= SMIN && m_low <= SMAX) begin m_evt = 1; m_kind = 0; end
        else if (m_low >= LMIN && m_low <= LMAX) begin m_evt = 1; m_kind = 1; end
        m_low = 0;
        m_fault = 0;
      end
      if (m_left > 0) begin
        m_left--;
        m_pull = (m_left > 0);
      end else if (req_valid && !busy) begin
        m_left = req_kind ? TXL : TXS;
        m_pull = 1;
      end
    end
  end

  // Per-cycle comparison and observation counters
  int ev_cnt = 0;
  int ev_kind_last = -1;
  int run = 0, last_run = 0, runs = 0;
  bit cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(line_pull == m_pull, "R2/R3/R9 line_pull vs model", line_pull, m_pull);
      chk(evt_valid == m_evt, "R4/R5/R6/R7 evt_valid vs model", evt_valid, m_evt);
      if (m_evt) chk(evt_kind == m_kind, "R5/R6 evt_kind vs model", evt_kind, m_kind);
      chk(fault == m_fault, "R8 fault vs model", fault, m_fault);
    end
    if (evt_valid) begin ev_cnt++; ev_kind_last = evt_kind; end
    if (line_pull) run++;
    else if (run > 0) begin last_run = run; runs++; run = 0; end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit k);
    req_kind = k; req_valid = 1'b1;
    cyc(1);
    req_valid = 1'b0;
  endtask

  task automatic ext(input int n);
    ext_pull = 1'b1;
    cyc(n);
    ext_pull = 1'b0;
  endtask

  task automatic expect_event(input int n0, input int kind, input string tag);
    chk(ev_cnt == n0 + 1, {tag, " event count"}, ev_cnt, n0 + 1);
    chk(ev_kind_last == kind, {tag, " event kind"}, ev_kind_last, kind);
  endtask

  initial begin
    int e0, r0;
    @(negedge clk); @(negedge clk);
    // R1 during reset
    chk(!line_pull && !evt_valid && !fault, "R1 outputs in reset", {line_pull, evt_valid, fault}, 0);
    @(negedge clk); rst = 1'b0;
    cmp_on = 1'b1;
    cyc(1);
    chk(!line_pull && !evt_valid && !fault, "R1 outputs after reset", {line_pull, evt_valid, fault}, 0);
    cyc(3);

    // R2 toggle request
    e0 = ev_cnt; send(0); cyc(20);
    chk(last_run == TXS, "R2 toggle pulse length", last_run, TXS);
    expect_event(e0, 0, "R2/R5 own toggle");

    // R3 OFF request
    e0 = ev_cnt; send(1); cyc(55);
    chk(last_run == TXL, "R3 OFF pulse length", last_run, TXL);
    expect_event(e0, 1, "R3/R6 own OFF");

    // R4 strobe timing after line rise
    e0 = ev_cnt; ext(10);
    cyc(2); chk(ev_cnt == e0, "R4 no strobe before third cycle", ev_cnt, e0);
    cyc(1); chk(evt_valid == 1'b1, "R4 strobe in third cycle", evt_valid, 1);
    cyc(1); chk(evt_valid == 1'b0, "R4 strobe lasts one cycle", evt_valid, 0);
    cyc(5);

    // R5 window edges
    e0 = ev_cnt; ext(SMIN); cyc(6); expect_event(e0, 0, "R5 low=SMIN");
    e0 = ev_cnt; ext(SMAX); cyc(6); expect_event(e0, 0, "R5 low=SMAX");
    // R6 window edges
    e0 = ev_cnt; ext(LMIN); cyc(6); expect_event(e0, 1, "R6 low=LMIN");
    e0 = ev_cnt; ext(LMAX); cyc(6); expect_event(e0, 1, "R6 low=LMAX");

    // R7 outside windows
    e0 = ev_cnt;
    ext(1); cyc(6); ext(SMIN-1); cyc(6); ext(SMAX+1); cyc(6);
    ext(LMIN-1); cyc(6); ext(LMAX+1); cyc(6); ext(TOUT-1); cyc(6);
    chk(ev_cnt == e0, "R7 ignored durations", ev_cnt, e0);
    chk(fault == 1'b0, "R7 no fault below timeout", fault, 0);

    // R8 timeout fault
    e0 = ev_cnt;
    ext_pull = 1'b1; cyc(TOUT + 5);
    chk(fault == 1'b1, "R8 fault while stuck low", fault, 1);
    ext_pull = 1'b0; cyc(3);
    chk(fault == 1'b0, "R8 fault clears on high line", fault, 0);
    cyc(5);
    chk(ev_cnt == e0, "R8 no strobe after fault", ev_cnt, e0);

    // R9 request while another device holds the line
    r0 = runs; e0 = ev_cnt;
    ext_pull = 1'b1; cyc(5); send(0); cyc(10); ext_pull = 1'b0;
    cyc(1); send(1); cyc(10);
    chk(runs == r0, "R9 request ignored while line busy", runs, r0);
    expect_event(e0, 0, "R9 only external pulse decoded");
    // R9 request during own pulse
    r0 = runs;
    send(0); cyc(3); send(1); cyc(20);
    chk(runs == r0 + 1, "R9 second request dropped", runs, r0 + 1);
    chk(last_run == TXS, "R9 own pulse unchanged", last_run, TXS);

    // R10 merged pulses
    e0 = ev_cnt;
    ext_pull = 1'b1; req_kind = 0; req_valid = 1'b1; cyc(1); req_valid = 1'b0;
    cyc(13); ext_pull = 1'b0; cyc(8);
    expect_event(e0, 0, "R10 merged 14-cycle pulse");
    e0 = ev_cnt;
    ext_pull = 1'b1; req_kind = 0; req_valid = 1'b1; cyc(1); req_valid = 1'b0;
    cyc(39); ext_pull = 1'b0; cyc(8);
    expect_event(e0, 1, "R10 merged 40-cycle pulse");

    cyc(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule